// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block guards a small word-addressed memory that several requesters share. Each requester presents an operation code, a word address, write data and its own request line. A round-robin arbiter accepts at most one request per clock. In that same cycle the block reads the addressed word, computes the replacement value and writes it back. No other access can fall between that read and that write. One cycle later it returns the word's previous contents, tagged with the accepted requester's index.

Five operations are supported:

- plain load and plain store;
- swap, which writes the supplied value and hands back the old one;
- test-and-set, which raises a zero word to 1;
- fetch-and-increment.

Lock code can use a word where 0 means free and 1 means held. A requester that swaps in 1, or runs test-and-set, and receives 0 owns the lock. A requester holds its request line and inputs steady until its ready line pulses, and then drops or changes them.

Top module: `amo_unit`

## Requirements
- R1: While rst_n is low at a clock edge, every req_ready bit is 0 and, after that edge, rsp_valid is 0. Every memory word reads as 0 after reset.
- R2: Opcode 3'd0 (load) returns the addressed word and leaves it unchanged.
- R3: Opcode 3'd1 (store) writes req_wdata into the word and returns the word's previous value.
- R4: Opcode 3'd2 (swap) writes req_wdata into the word and returns the previous value. Two swaps of 1 into a free (0) word return 0 and then 1.
- R5: Opcode 3'd3 (test-and-set) writes 1 when the word is 0 and leaves a nonzero word unchanged. It returns the previous value in both cases.
- R6: Opcode 3'd4 (fetch-and-increment) returns the previous value and stores that value plus one, modulo 2^DW. An all-ones word becomes 0.
- R7: At most one req_ready bit is high in any cycle, and only for a requester whose req_valid is high. A request that is alone is accepted in the cycle it is presented.
- R8: Priority rotates. After requester g is accepted, requester (g+1) mod NREQ has first claim in the next cycle, followed by the next indices in ascending order with wrap-around.
- R9: Each acceptance produces exactly one response, with rsp_valid high for the single following cycle. rsp_id is the accepted index and rsp_data is the word's value before the operation. rsp_valid is low after any cycle without an acceptance.
- R10: Opcodes 3'd5, 3'd6 and 3'd7 act as loads: they return the word and never modify it.
- R11: Operations accepted in consecutive cycles on the same address each observe the result of the one before. NREQ simultaneous fetch-and-increments of a word holding v return v, v+1, … in acceptance order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | NREQ | Request pending, one bit per requester |
| req_op | input | 3*NREQ | Operation code per requester, requester i in bits [3i+2:3i] |
| req_addr | input | AW*NREQ | Word address per requester |
| req_wdata | input | DW*NREQ | Write/swap data per requester |
| req_ready | output | NREQ | One-hot acceptance pulse for the chosen requester |
| rsp_valid | output | 1 | Response strobe, one cycle per accepted request |
| rsp_id | output | IDW | Index of the requester the response belongs to |
| rsp_data | output | DW | Memory word value before the operation |

## Verification
The bench builds the block with NREQ=4, AW=4 and DW=16. With four requesters, full four-way contention on one word shows the priority rotating through every index and back to index 0. That same contention drives an ordered chain of read-modify-writes on the word. A 16-bit word is small enough for the bench to store the all-ones value directly and watch fetch-and-increment wrap to 0. The sixteen words are few enough to sweep every address after reset.

// File: rtl/amo_pkg.sv
// Package: shared operation encoding for the atomic memory operation unit.
// Assumes a 3-bit opcode field; codes 5..7 are reserved and behave as loads.
package amo_pkg;

    localparam int OPW = 3;

    typedef enum logic [OPW-1:0] {
        AMO_LOAD  = 3'd0,
        AMO_STORE = 3'd1,
        AMO_SWAP  = 3'd2,
        AMO_TAS   = 3'd3,
        AMO_FINC  = 3'd4
    } amo_op_e;

endpackage

// File: rtl/amo_rr_arbiter.sv
// Module: rotating-priority arbiter.
// Picks at most one valid requester per cycle, searching upward from a
// pointer that moves to one past the last winner. Assumes NREQ >= 1.
module amo_rr_arbiter #(
    parameter int NREQ = 4,
    parameter int IDW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREQ-1:0]  valid,
    output logic [NREQ-1:0]  grant,
    output logic [IDW-1:0]   grant_idx,
    output logic             grant_any
);

    logic [IDW-1:0] start_q;

    // Search from start_q upward with wrap-around for the first valid requester.
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        grant_any = 1'b0;
        for (int i = 0; i < NREQ; i++) begin
            int cand;
            cand = int'(start_q) + i;
            if (cand >= NREQ) cand = cand - NREQ;
            if (rst_n && !grant_any && valid[cand]) begin
                grant_any   = 1'b1;
                grant[cand] = 1'b1;
                grant_idx   = IDW'(cand);
            end
        end
    end

    // Move the search start to one past the most recent winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (grant_any) begin
            if (int'(grant_idx) == NREQ - 1) start_q <= '0;
            else                             start_q <= grant_idx + IDW'(1);
        end
    end

endmodule

// File: rtl/amo_alu.sv
// Module: combinational read-modify-write rule.
// Given the opcode, the word's current value and the supplied data, returns
// whether the word is written and with what. Reserved codes never write.
module amo_alu
    import amo_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  old_val,
    input  logic [DW-1:0]  wdata,
    output logic           wr_en,
    output logic [DW-1:0]  new_val
);

    // Select the replacement value and write enable for each operation.
    always_comb begin
        wr_en   = 1'b0;
        new_val = old_val;
        case (op)
            AMO_STORE,
            AMO_SWAP: begin
                wr_en   = 1'b1;
                new_val = wdata;
            end
            AMO_TAS: begin
                wr_en   = (old_val == '0);
                new_val = DW'(1);
            end
            AMO_FINC: begin
                wr_en   = 1'b1;
                new_val = old_val + DW'(1);
            end
            default: begin
                wr_en   = 1'b0;
                new_val = old_val;
            end
        endcase
    end

endmodule

// File: rtl/amo_mem.sv
// Module: word storage with a combinational read port and a clocked write port.
// Assumes a single writer. Every word clears to zero under reset.
module amo_mem #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words_q [DEPTH];

    // Read the addressed word in the same cycle.
    always_comb begin
        rd_data = words_q[rd_addr];
    end

    // Clear all words under reset, otherwise apply the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words_q[i] <= '0;
        end else if (wr_en) begin
            words_q[wr_addr] <= wr_data;
        end
    end

endmodule

// File: rtl/amo_unit.sv
// Module: atomic memory operation unit (top).
// Accepts one request per cycle by rotating priority. The read and the
// write-back of the chosen operation happen within that one cycle, so no
// other access can fall between them. The old value is returned one cycle later.
// Assumes each requester holds its inputs until its req_ready pulse.
module amo_unit
    import amo_pkg::*;
#(
    parameter int NREQ = 4,
    parameter int AW   = 4,
    parameter int DW   = 16,
    parameter int IDW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NREQ-1:0]     req_valid,
    input  logic [NREQ*OPW-1:0] req_op,
    input  logic [NREQ*AW-1:0]  req_addr,
    input  logic [NREQ*DW-1:0]  req_wdata,
    output logic [NREQ-1:0]     req_ready,
    output logic                rsp_valid,
    output logic [IDW-1:0]      rsp_id,
    output logic [DW-1:0]       rsp_data
);

    logic [IDW-1:0] win_idx;
    logic           win_any;
    logic [OPW-1:0] sel_op;
    logic [AW-1:0]  sel_addr;
    logic [DW-1:0]  sel_wdata;
    logic [DW-1:0]  cur_word;
    logic           alu_wr;
    logic [DW-1:0]  alu_new;

    amo_rr_arbiter #(.NREQ(NREQ), .IDW(IDW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (req_valid),
        .grant     (req_ready),
        .grant_idx (win_idx),
        .grant_any (win_any)
    );

    // Steer the winning requester's fields onto the shared datapath.
    always_comb begin
        sel_op    = '0;
        sel_addr  = '0;
        sel_wdata = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (int'(win_idx) == i) begin
                sel_op    = req_op[i*OPW +: OPW];
                sel_addr  = req_addr[i*AW +: AW];
                sel_wdata = req_wdata[i*DW +: DW];
            end
        end
    end

    amo_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (sel_addr),
        .rd_data (cur_word),
        .wr_en   (win_any && alu_wr),
        .wr_addr (sel_addr),
        .wr_data (alu_new)
    );

    amo_alu #(.DW(DW)) u_alu (
        .op      (sel_op),
        .old_val (cur_word),
        .wdata   (sel_wdata),
        .wr_en   (alu_wr),
        .new_val (alu_new)
    );

    // Register the response: pulse the strobe and hold the old word and the requester index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_id    <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= win_any;
            if (win_any) begin
                rsp_id   <= win_idx;
                rsp_data <= cur_word;
            end
        end
    end

endmodule

// File: rtl/amo_unit_chk.sv
// Module: protocol checker for amo_unit, attached by bind.
// Observes only the top-level ports; keeps the last winner in a local register.
module amo_unit_chk #(
    parameter int NREQ = 4,
    parameter int IDW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NREQ-1:0] req_valid,
    input logic [NREQ-1:0] req_ready,
    input logic            rsp_valid,
    input logic [IDW-1:0]  rsp_id
);

    logic [IDW-1:0] rdy_idx;
    logic [IDW-1:0] last_idx;
    logic           last_vld;
    logic [IDW-1:0] next_idx;

    // Encode the one-hot ready vector into an index.
    always_comb begin
        rdy_idx = '0;
        for (int i = 0; i < NREQ; i++) if (req_ready[i]) rdy_idx = IDW'(i);
    end

    // Remember the most recent winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_vld <= 1'b0;
            last_idx <= '0;
        end else if (|req_ready) begin
            last_vld <= 1'b1;
            last_idx <= rdy_idx;
        end else begin
            last_vld <= 1'b0;
        end
    end

    // Compute the index that must have first claim after the last winner.
    always_comb begin
        if (int'(last_idx) == NREQ - 1) next_idx = '0;
        else                            next_idx = last_idx + IDW'(1);
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid);

    p_reset_no_grant_r1: assert property (@(posedge clk)
        !rst_n |-> (req_ready == '0));

    p_single_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    p_grant_only_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);

    p_work_conserving_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_valid) |-> (|req_ready));

    p_rotate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (last_vld && req_valid[next_idx]) |-> req_ready[next_idx]);

    p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_ready) |=> (rsp_valid && rsp_id == $past(rdy_idx)));

    p_rsp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_ready) |=> !rsp_valid);

endmodule

bind amo_unit amo_unit_chk #(.NREQ(NREQ), .IDW(IDW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_id    (rsp_id)
);

// File: tb/amo_unit_tb.sv
// Scoreboard bench for amo_unit. The driver keeps a shadow memory and a
// rotating-priority model taken from the requirements. It pushes each
// expected response into a queue; a monitor pops and compares.
module amo_unit_tb;

    localparam int NREQ = 4;
    localparam int AW   = 4;
    localparam int DW   = 16;
    localparam int IDW  = 2;
    localparam int OPW  = 3;
    localparam int DEPTH = 1 << AW;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NREQ-1:0]     req_valid = '0;
    logic [NREQ*OPW-1:0] req_op = '0;
    logic [NREQ*AW-1:0]  req_addr = '0;
    logic [NREQ*DW-1:0]  req_wdata = '0;
    logic [NREQ-1:0]     req_ready;
    logic                rsp_valid;
    logic [IDW-1:0]      rsp_id;
    logic [DW-1:0]       rsp_data;

    always #2 clk = ~clk;

    amo_unit #(.NREQ(NREQ), .AW(AW), .DW(DW), .IDW(IDW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data)
    );

    typedef struct {
        logic [IDW-1:0] id;
        logic [DW-1:0]  data;
        string          tag;
    } exp_t;

    exp_t          sb_q[$];
    int            checks = 0;
    int            fails  = 0;
    bit            pend [NREQ];
    logic [2:0]    p_op [NREQ];
    logic [AW-1:0] p_adr[NREQ];
    logic [DW-1:0] p_wd [NREQ];
    string         p_tag[NREQ];
    logic [DW-1:0] shadow[DEPTH];
    int            rr_next = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Queue a request for requester k; it stays pending until accepted.
    task automatic post(input int k, input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input string tag);
        pend[k]  = 1'b1;
        p_op[k]  = op;
        p_adr[k] = a;
        p_wd[k]  = wd;
        p_tag[k] = tag;
    endtask

    // One cycle: drive pending requests, check acceptance, update the model.
    task automatic step();
        int g;
        logic [NREQ-1:0] exp_rdy;
        @(negedge clk);
        for (int k = 0; k < NREQ; k++) begin
            req_valid[k]             = pend[k];
            req_op[k*OPW +: OPW]     = p_op[k];
            req_addr[k*AW +: AW]     = p_adr[k];
            req_wdata[k*DW +: DW]    = p_wd[k];
        end
        #1;
        g = -1;
        for (int i = 0; i < NREQ; i++) begin
            int c;
            c = (rr_next + i) % NREQ;
            if (g < 0 && pend[c]) g = c;
        end
        exp_rdy = '0;
        if (g >= 0) exp_rdy[g] = 1'b1;
        // R7 single acceptance to a valid requester; R8 rotation order
        check(req_ready == exp_rdy, (g >= 0) ? "R8" : "R7", "req_ready",
              longint'(req_ready), longint'(exp_rdy));
        if (g >= 0) begin
            logic [DW-1:0] old;
            exp_t e;
            old = shadow[p_adr[g]];
            case (p_op[g])
                3'd1, 3'd2: shadow[p_adr[g]] = p_wd[g];
                3'd3:       if (old == '0) shadow[p_adr[g]] = DW'(1);
                3'd4:       shadow[p_adr[g]] = old + DW'(1);
                default:    ;
            endcase
            e.id = IDW'(g);
            e.data = old;
            e.tag = p_tag[g];
            sb_q.push_back(e);
            pend[g] = 1'b0;
            rr_next = (g + 1) % NREQ;
        end
    endtask

    task automatic drain();
        bit busy;
        busy = 1'b1;
        while (busy) begin
            busy = 1'b0;
            for (int k = 0; k < NREQ; k++) if (pend[k]) busy = 1'b1;
            if (busy) step();
        end
        repeat (2) step();
        check(sb_q.size() == 0, "R9", "outstanding responses", sb_q.size(), 0);
    endtask

    // Monitor: every response must match the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R9", "unexpected rsp_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(rsp_id == e.id, "R9", "rsp_id", rsp_id, e.id);
                check(rsp_data == e.data, e.tag, "rsp_data", rsp_data, e.data);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < NREQ; k++) begin
            pend[k] = 1'b0; p_op[k] = '0; p_adr[k] = '0; p_wd[k] = '0; p_tag[k] = "";
        end
        for (int a = 0; a < DEPTH; a++) shadow[a] = '0;

        // R1: during reset no acceptance and no response, even with requests present
        req_valid = '1;
        repeat (3) begin
            @(negedge clk);
            check(req_ready == '0, "R1", "req_ready in reset", req_ready, 0);
            check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
        end
        req_valid = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1: all words read back zero; R2 plain loads
        for (int a = 0; a < DEPTH; a++) begin
            post(a % NREQ, 3'd0, AW'(a), '0, "R1");
            drain();
        end

        // R3 stores from several requesters, then R2 loads
        post(0, 3'd1, 4'd1, 16'h1234, "R3"); drain();
        post(2, 3'd1, 4'd1, 16'hBEEF, "R3"); drain();
        post(1, 3'd0, 4'd1, 16'h0000, "R2"); drain();
        post(3, 3'd0, 4'd1, 16'hFFFF, "R2"); drain();

        // R4 swap used as a lock on word 3
        post(1, 3'd2, 4'd3, 16'd1, "R4"); drain();
        post(2, 3'd2, 4'd3, 16'd1, "R4"); drain();
        post(0, 3'd2, 4'd3, 16'd0, "R4"); drain();
        post(3, 3'd0, 4'd3, 16'd9, "R4"); drain();

        // R5 test-and-set on zero and on nonzero words
        post(0, 3'd3, 4'd5, 16'h0, "R5"); drain();
        post(1, 3'd3, 4'd5, 16'h0, "R5"); drain();
        post(2, 3'd1, 4'd6, 16'h0007, "R5"); drain();
        post(3, 3'd3, 4'd6, 16'h0, "R5"); drain();
        post(0, 3'd0, 4'd6, 16'h0, "R5"); drain();

        // R6 fetch-and-increment with wrap-around
        post(1, 3'd1, 4'd9, 16'hFFFF, "R6"); drain();
        post(2, 3'd4, 4'd9, 16'h0, "R6"); drain();
        post(3, 3'd0, 4'd9, 16'h0, "R6"); drain();
        post(0, 3'd4, 4'd9, 16'h0, "R6"); drain();

        // R10 reserved opcodes must not write
        post(0, 3'd1, 4'd2, 16'h00AA, "R10"); drain();
        post(1, 3'd5, 4'd2, 16'h1111, "R10");
        post(2, 3'd6, 4'd2, 16'h2222, "R10");
        post(3, 3'd7, 4'd2, 16'h3333, "R10");
        drain();
        post(0, 3'd0, 4'd2, 16'h0, "R10"); drain();

        // R11 full contention on one word: increments chain in acceptance order
        for (int k = 0; k < NREQ; k++) post(k, 3'd4, 4'd10, '0, "R11");
        drain();
        // R11 contention on a lock: only the first test-and-set sees zero
        for (int k = 0; k < NREQ; k++) post(k, 3'd3, 4'd11, '0, "R11");
        drain();

        // R8 rotation with staggered arrivals and mixed operations
        for (int r = 0; r < 6; r++) begin
            post(3, 3'd4, 4'd12, '0, "R8");
            post(0, 3'd4, 4'd12, '0, "R8");
            post(r % NREQ, 3'd2, 4'd13, DW'(r), "R8");
            step();
            post((r + 1) % NREQ, 3'd0, 4'd12, '0, "R8");
            drain();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule